// File: doc/BRIEF.md
# Column-Mapped Memory Board Select Decoder

This block decodes the bus address for a 32K static memory board built as eight columns. Each column is a complete 4K-by-8 bank. The 64K address space is split into sixteen 4K blocks, selected by address bits 15 to 12. Any column can be placed at any block. The placement comes from a small configuration store that takes the place of wire jumpers. Software, or a boot sequence, writes one column entry at a time. Each entry holds a 4-bit block number and a valid flag.

Two further address bits, 17 and 16, extend the reach to 256K. When memory management is enabled, these bits must equal a configured 2-bit bank number. The values 0 to 3 select the 0–64K, 64K–128K, 128K–192K and 192K–256K regions. When memory management is off, the board answers only in the lowest 64K. A phantom input, when its use is enabled and the line is low, deselects the whole board.

The outputs are eight active-low column chip selects and a board-select strobe. The strobe is used to open the read data buffer. The chip selects and the strobe are combinational from the address and the stored map. There is no state machine; the only storage is the map.

Top module: `bsel_decoder`

## Requirements
- R1: After reset, every column is unmapped, all `cs_n` bits are 1 and `board_sel` is 0.
- R2: A write with `cfg_wr`=1 stores `cfg_blk` and `cfg_vld` for column `cfg_col` at the clock edge. The decode uses the new entry from that edge on, and not before it.
- R3: Column k drives `cs_n[k]`=0 when all of these hold: its entry is valid, `addr[15:12]` equals its block number, the extended-bank condition holds, and phantom is not active.
- R4: A column whose valid flag is 0 never asserts its select, whatever its stored block number.
- R5: At most one `cs_n` bit is 0 at a time. When several valid columns map to the addressed block, only the lowest-numbered of them is asserted.
- R6: With `mm_en`=1, no select asserts unless `addr[17:16]` equals `bank_cfg`.
- R7: With `mm_en`=0, no select asserts unless `addr[17:16]` is 0, and `bank_cfg` has no effect.
- R8: With `phantom_en`=1 and `phantom_n`=0, all selects are 1. With `phantom_en`=0, `phantom_n` has no effect.
- R9: `board_sel` is 1 exactly when one `cs_n` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map store |
| rst_n | input | 1 | Active-low reset; clears every map entry |
| cfg_wr | input | 1 | Map write strobe |
| cfg_col | input | 3 | Column written by this map write |
| cfg_blk | input | 4 | 4K block number for that column |
| cfg_vld | input | 1 | Valid flag for that column |
| mm_en | input | 1 | Enables the extended bank compare |
| bank_cfg | input | 2 | Bank that address bits 17:16 must match |
| phantom_en | input | 1 | Enables the phantom disable |
| phantom_n | input | 1 | Bus phantom line, active low |
| addr | input | 18 | Bus address |
| cs_n | output | 8 | Active-low column chip selects |
| board_sel | output | 1 | High while any column is selected |

## Verification
The bench sweeps every block number and every value of the extended bits. It does this under both memory-management settings, all four bank values and all four phantom combinations, and against two maps. The second map places two valid columns on the same block and leaves a column with a matching block but no valid flag. A design with the wrong priority would drive two columns at once or pick the higher one. A design that ignored the valid flag would select an unmapped column.

With memory management off, the bench drives a nonzero extended address. A decoder that forgot the base-64K rule would then answer in every region. A separate step checks that a map write changes the decode only after its clock edge, which catches a store that passes the write straight through.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int unsigned COLS_DEF  = 8;
    localparam int unsigned BLK_W_DEF = 4;
    localparam int unsigned EXT_W_DEF = 2;
    localparam int unsigned BASE_W    = 16;

    // Extended-bank qualifier: match the bank when enabled, else base region only
    function automatic logic ext_ok(input logic mm, input logic [EXT_W_DEF-1:0] hi,
                                    input logic [EXT_W_DEF-1:0] bank);
        if (mm) return (hi == bank);
        return (hi == '0);
    endfunction
endpackage

// File: rtl/bsel_map_store.sv
module bsel_map_store #(
    parameter int unsigned N_COLS = 8,
    parameter int unsigned BLK_W  = 4,
    localparam int unsigned COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [COL_W-1:0]        col,
    input  logic [BLK_W-1:0]        blk,
    input  logic                    vld,
    output logic [N_COLS-1:0]       map_vld,
    output logic [N_COLS*BLK_W-1:0] map_blk
);
    for (genvar k = 0; k < N_COLS; k++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_vld[k]                  <= 1'b0;
                map_blk[k*BLK_W +: BLK_W]   <= '0;
            end else if (wr && (col == COL_W'(k))) begin
                map_vld[k]                  <= vld;
                map_blk[k*BLK_W +: BLK_W]   <= blk;
            end
        end
    end
endmodule

// File: rtl/bsel_col_match.sv
module bsel_col_match #(
    parameter int unsigned N_COLS = 8,
    parameter int unsigned BLK_W  = 4
) (
    input  logic [N_COLS-1:0]       map_vld,
    input  logic [N_COLS*BLK_W-1:0] map_blk,
    input  logic [BLK_W-1:0]        blk_addr,
    input  logic                    gate,
    output logic [N_COLS-1:0]       hit
);
    for (genvar k = 0; k < N_COLS; k++) begin : g_cmp
        assign hit[k] = gate && map_vld[k] && (map_blk[k*BLK_W +: BLK_W] == blk_addr);
    end
endmodule

// File: rtl/bsel_lowest_pick.sv
module bsel_lowest_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsel_decoder.sv
module bsel_decoder #(
    parameter int unsigned N_COLS = bsel_pkg::COLS_DEF,
    parameter int unsigned BLK_W  = bsel_pkg::BLK_W_DEF,
    parameter int unsigned EXT_W  = bsel_pkg::EXT_W_DEF,
    localparam int unsigned COL_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1,
    localparam int unsigned ADDR_W = bsel_pkg::BASE_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic [BLK_W-1:0]  cfg_blk,
    input  logic              cfg_vld,
    input  logic              mm_en,
    input  logic [EXT_W-1:0]  bank_cfg,
    input  logic              phantom_en,
    input  logic              phantom_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_COLS-1:0] cs_n,
    output logic              board_sel
);
    logic [N_COLS-1:0]       map_vld;
    logic [N_COLS*BLK_W-1:0] map_blk;
    logic [N_COLS-1:0]       hit;
    logic [N_COLS-1:0]       gnt;
    logic                    bank_ok;
    logic                    gate;
    logic [BLK_W-1:0]        blk_addr;
    logic [EXT_W-1:0]        ext_hi;

    assign blk_addr = addr[bsel_pkg::BASE_W-1 -: BLK_W];
    assign ext_hi   = addr[ADDR_W-1 -: EXT_W];

    if (EXT_W == bsel_pkg::EXT_W_DEF) begin : g_ext_pkg
        assign bank_ok = bsel_pkg::ext_ok(mm_en, ext_hi, bank_cfg);
    end else begin : g_ext_gen
        assign bank_ok = mm_en ? (ext_hi == bank_cfg) : (ext_hi == '0);
    end

    assign gate = bank_ok && !(phantom_en && !phantom_n);

    bsel_map_store #(.N_COLS(N_COLS), .BLK_W(BLK_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .col(cfg_col),
        .blk(cfg_blk), .vld(cfg_vld), .map_vld(map_vld), .map_blk(map_blk)
    );

    bsel_col_match #(.N_COLS(N_COLS), .BLK_W(BLK_W)) match_i (
        .map_vld(map_vld), .map_blk(map_blk), .blk_addr(blk_addr),
        .gate(gate), .hit(hit)
    );

    bsel_lowest_pick #(.N(N_COLS)) pick_i (.req(hit), .gnt(gnt));

    assign cs_n      = ~gnt;
    assign board_sel = |gnt;
endmodule

// File: rtl/bsel_decoder_chk.sv
module bsel_decoder_chk #(
    parameter int unsigned N_COLS = 8,
    parameter int unsigned EXT_W  = 2,
    parameter int unsigned ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mm_en,
    input logic [EXT_W-1:0]  bank_cfg,
    input logic              phantom_en,
    input logic              phantom_n,
    input logic [ADDR_W-1:0] addr,
    input logic [N_COLS-1:0] cs_n,
    input logic              board_sel
);
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cs_n == '1 && !board_sel));

    assert_single_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_bank_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_en && addr[ADDR_W-1 -: EXT_W] != bank_cfg) |-> cs_n == '1);

    assert_base_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mm_en && addr[ADDR_W-1 -: EXT_W] != '0) |-> cs_n == '1);

    assert_phantom_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phantom_en && !phantom_n) |-> cs_n == '1);

    assert_strobe_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        board_sel == ($countones(~cs_n) == 1));
endmodule

bind bsel_decoder bsel_decoder_chk #(
    .N_COLS(N_COLS), .EXT_W(EXT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .bank_cfg(bank_cfg),
    .phantom_en(phantom_en), .phantom_n(phantom_n), .addr(addr),
    .cs_n(cs_n), .board_sel(board_sel)
);

// File: tb/bsel_decoder_tb.sv
module bsel_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_col = '0;
    logic [3:0]  cfg_blk = '0;
    logic        cfg_vld = 1'b0;
    logic        mm_en = 1'b0;
    logic [1:0]  bank_cfg = '0;
    logic        phantom_en = 1'b0;
    logic        phantom_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  cs_n;
    logic        board_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] mb [8];
    logic       mv [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bsel_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_col(cfg_col),
        .cfg_blk(cfg_blk), .cfg_vld(cfg_vld), .mm_en(mm_en), .bank_cfg(bank_cfg),
        .phantom_en(phantom_en), .phantom_n(phantom_n), .addr(addr),
        .cs_n(cs_n), .board_sel(board_sel)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b addr=%h mm=%b bank=%0d pe=%b pn=%b",
                     req, act, exp, addr, mm_en, bank_cfg, phantom_en, phantom_n);
        end
    endtask

    task automatic put_cfg(input int c, input logic [3:0] b, input logic v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_col = 3'(c); cfg_blk = b; cfg_vld = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        mb[c] = b; mv[c] = v;
    endtask

    function automatic logic [7:0] model_cs_n();
        logic ok;
        ok = mm_en ? (addr[17:16] == bank_cfg) : (addr[17:16] == 2'd0);
        if (phantom_en && !phantom_n) ok = 1'b0;
        if (ok)
            for (int i = 0; i < 8; i++)
                if (mv[i] && mb[i] == addr[15:12]) return ~(8'b1 << i);
        return 8'hFF;
    endfunction

    function automatic string pick_tag();
        int n = 0;
        logic inv = 1'b0;
        if (phantom_en && !phantom_n) return "R8";
        if (mm_en && addr[17:16] != bank_cfg) return "R6";
        if (!mm_en && addr[17:16] != 2'd0) return "R7";
        for (int i = 0; i < 8; i++) begin
            if (mv[i] && mb[i] == addr[15:12]) n++;
            if (!mv[i] && mb[i] == addr[15:12]) inv = 1'b1;
        end
        if (n > 1) return "R5";
        if (inv) return "R4";
        return "R3";
    endfunction

    task automatic sweep();
        for (int e = 0; e < 64; e++)
            for (int m = 0; m < 2; m++)
                for (int b = 0; b < 4; b++)
                    for (int p = 0; p < 4; p++) begin
                        logic [7:0] exp;
                        @(negedge clk);
                        addr = {6'(e), 12'((e * 97 + b * 13) & 12'hFFF)};
                        mm_en = m[0]; bank_cfg = 2'(b);
                        phantom_en = p[1]; phantom_n = p[0];
                        #1;
                        exp = model_cs_n();
                        check(pick_tag(), {1'b0, cs_n}, {1'b0, exp});
                        check("R9", {8'h0, board_sel}, {8'h0, exp != 8'hFF});
                    end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mb[i] = '0; mv[i] = 1'b0; end
        repeat (3) @(negedge clk);
        addr = 18'h00000;
        #1;
        check("R1", {cs_n, board_sel}, {8'hFF, 1'b0});
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", {cs_n, board_sel}, {8'hFF, 1'b0});

        // R2: write col 2 -> block 9, visible only after the edge
        @(negedge clk);
        addr = 18'h09123;
        cfg_wr = 1'b1; cfg_col = 3'd2; cfg_blk = 4'd9; cfg_vld = 1'b1;
        #1;
        check("R2", {cs_n, board_sel}, {8'hFF, 1'b0});
        @(negedge clk);
        cfg_wr = 1'b0;
        mb[2] = 4'd9; mv[2] = 1'b1;
        #1;
        check("R2", {cs_n, board_sel}, {8'hFB, 1'b1});

        // Map A: column c at block 2c
        for (int c = 0; c < 8; c++) put_cfg(c, 4'(2 * c), 1'b1);
        sweep();

        // Map B: duplicates and unmapped columns
        put_cfg(0, 4'd7, 1'b0);
        put_cfg(1, 4'd1, 1'b1);
        put_cfg(2, 4'd15, 1'b1);
        put_cfg(3, 4'd7, 1'b1);
        put_cfg(4, 4'd15, 1'b1);
        put_cfg(5, 4'd7, 1'b1);
        put_cfg(6, 4'd0, 1'b0);
        put_cfg(7, 4'd0, 1'b1);
        sweep();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule